// File: doc/BRIEF.md
# Dual-Byte Running Disparity Tracker

This block sits in front of an 8b/10b encoder that encodes two bytes per clock but does not report its own running disparity. For every 16-bit word it decides whether encoding each byte will invert the running disparity. From those decisions it works out the disparity each byte must start with, and the disparity left at the end of the word. It passes the starting disparities to the encoder as force-disparity values, so the encoder and the tracker never disagree.

When no data is offered, the block sends one of two IDLE ordered sets. Both put a K28.5 comma in the low byte. The second byte is chosen from the current running disparity, so a receiver that synchronizes on commas always sees a comma with legal disparity. Each byte's flip bit is a registered lookup that takes one clock, so the word is delayed one cycle to stay aligned with its flip bits.

Top module: `disp_track`

## Requirements
- R1: While reset is held and after it is released, the tracked running disparity is negative (0). The first word presented at the output is the negative-disparity IDLE: outData=16'h50BC, outK=2'b01.
- R2: A valid input word sampled on a rising edge appears on outData and outK after that edge, one cycle of latency, unchanged.
- R3: A byte's flip bit is 1 exactly when one of its two parts has unbalanced disparity and the other does not. The 5-bit part (bits 4:0) is unbalanced for values 0,1,2,4,8,15,16,23,24,27,29,30,31. The 3-bit part (bits 7:5) is unbalanced for values 0,4,7.
- R4: outDisp[0], the forced start disparity of the low byte (1 = positive), equals the running disparity at the end of the previous output word.
- R5: outDisp[1], the start disparity of the high byte, equals outDisp[0] inverted when the low byte flips.
- R6: outRdEnd equals outDisp[1] inverted when the high byte flips. It becomes the starting disparity of the next word.
- R7: A cycle with inValid low produces an IDLE one cycle later. The IDLE has K28.5 (8'hBC) in the low byte and outK=2'b01.
- R8: The IDLE high byte is D5.6 (8'hC5) when the running disparity before the IDLE is positive, and D16.2 (8'h50) when it is negative.
- R9: The running disparity at the end of every IDLE is negative.
- R10: A byte flagged as a control character (inK bit set) with 5-bit part 28 counts as unbalanced in that part. The same byte value sent as data counts as balanced there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | inData holds a word to send; when low, an IDLE is sent |
| inData | input | 16 | Input word; the low byte is sent first |
| inK | input | 2 | Control-character flag per byte |
| outData | output | 16 | Word to the encoder, delayed one cycle |
| outK | output | 2 | Control-character flag per byte to the encoder |
| outDisp | output | 2 | Forced start disparity per byte (1 = positive) |
| outRdEnd | output | 1 | Running disparity after the current word |

## Verification
The bench holds its own reference for disparity and compares every output field on every cycle.

It drives IDLEs after both positive and negative disparity. A design that picked the IDLE from stale or inverted disparity would put the wrong second byte in the IDLE. It sends bytes that flip in one part but not the other, and bytes that flip in neither or in both. A design that combined the two parts wrongly would drift and leave every later forced disparity wrong.

It sends 8'hBC both with and without the control flag, to catch a design that ignores the control table. It also sends back-to-back words, to catch a design whose flip bits are off by one cycle from their data.

// File: rtl/disp_track_pkg.sv
package disp_track_pkg;
  localparam int LANES  = 2;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  localparam logic [BYTE_W-1:0] COMMA_K285 = 8'hBC;
  localparam logic [BYTE_W-1:0] IDLE_POS   = 8'hC5; // D5.6
  localparam logic [BYTE_W-1:0] IDLE_NEG   = 8'h50; // D16.2
  localparam logic [31:0] UNBAL5_MASK      = 32'hE981_8117;
  localparam int K28_CODE                  = 28;

  typedef struct packed {
    logic useIdle;
    logic pickPos;
  } rdtStrobe_t;

  function automatic logic byteFlips(input logic [BYTE_W-1:0] b, input logic isK);
    logic u5, u3;
    u5 = UNBAL5_MASK[b[4:0]] | (isK && (b[4:0] == 5'(K28_CODE)));
    u3 = (b[7:5] == 3'd0) || (b[7:5] == 3'd4) || (b[7:5] == 3'd7);
    return u5 ^ u3;
  endfunction
endpackage

// File: rtl/disp_track_dp.sv
module disp_track_dp
  import disp_track_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  input  logic [LANES-1:0]  inK,
  input  rdtStrobe_t        strobe,
  output logic              stgIdle,
  output logic [LANES-1:0]  laneFlip,
  output logic [WORD_W-1:0] outData,
  output logic [LANES-1:0]  outK
);
  logic [WORD_W-1:0] stgData;
  logic [LANES-1:0]  stgK;

  always_ff @(posedge clk) begin
    if (!rstN) stgIdle <= 1'b1;
    else       stgIdle <= !inValid;
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stgData[ln*BYTE_W +: BYTE_W] <= '0;
        stgK[ln]                     <= 1'b0;
        laneFlip[ln]                 <= 1'b0;
      end else begin
        stgData[ln*BYTE_W +: BYTE_W] <= inData[ln*BYTE_W +: BYTE_W];
        stgK[ln]                     <= inK[ln];
        laneFlip[ln]                 <= byteFlips(inData[ln*BYTE_W +: BYTE_W], inK[ln]);
      end
    end
  end

  always_comb begin
    if (strobe.useIdle) begin
      outData = {(strobe.pickPos ? IDLE_POS : IDLE_NEG), COMMA_K285};
      outK    = 2'b01;
    end else begin
      outData = stgData;
      outK    = stgK;
    end
  end
endmodule

// File: rtl/disp_track_ctl.sv
module disp_track_ctl
  import disp_track_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             stgIdle,
  input  logic [LANES-1:0] laneFlip,
  output rdtStrobe_t       strobe,
  output logic [LANES-1:0] startDisp,
  output logic             rdEnd
);
  logic             rdReg;
  logic [LANES-1:0] flipEff;

  always_comb begin
    flipEff[0] = stgIdle ? 1'b1 : laneFlip[0];
    flipEff[1] = stgIdle ? !rdReg : laneFlip[1];
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_chain
    if (ln == 0) begin : g_first
      assign startDisp[ln] = rdReg;
    end else begin : g_next
      assign startDisp[ln] = startDisp[ln-1] ^ flipEff[ln-1];
    end
  end

  assign rdEnd = startDisp[LANES-1] ^ flipEff[LANES-1];

  always_ff @(posedge clk) begin
    if (!rstN) rdReg <= 1'b0;
    else       rdReg <= rdEnd;
  end

  assign strobe.useIdle = stgIdle;
  assign strobe.pickPos = rdReg;
endmodule

// File: rtl/disp_track.sv
module disp_track
  import disp_track_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [15:0] inData,
  input  logic [1:0]  inK,
  output logic [15:0] outData,
  output logic [1:0]  outK,
  output logic [1:0]  outDisp,
  output logic        outRdEnd
);
  rdtStrobe_t       strobe;
  logic             stgIdle;
  logic [LANES-1:0] laneFlip;

  disp_track_dp u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inK(inK),
    .strobe(strobe), .stgIdle(stgIdle), .laneFlip(laneFlip),
    .outData(outData), .outK(outK)
  );

  disp_track_ctl u_ctl (
    .clk(clk), .rstN(rstN), .stgIdle(stgIdle), .laneFlip(laneFlip),
    .strobe(strobe), .startDisp(outDisp), .rdEnd(outRdEnd)
  );
endmodule

// File: rtl/disp_track_chk.sv
module disp_track_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [15:0] inData,
  input logic [15:0] outData,
  input logic [1:0]  outK,
  input logic [1:0]  outDisp,
  input logic        outRdEnd
);
  a_r2_data_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outData == $past(inData)));

  a_r7_idle_comma: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (outData[7:0] == 8'hBC && outK == 2'b01));

  a_r8_idle_variant: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (outData[15:8] == (outDisp[0] ? 8'hC5 : 8'h50)));

  a_r4_chain: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outDisp[0] == $past(outRdEnd)));

  a_r9_idle_ends_neg: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outRdEnd);
endmodule

bind disp_track disp_track_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
  .outData(outData), .outK(outK), .outDisp(outDisp), .outRdEnd(outRdEnd)
);

// File: tb/disp_track_bench.sv
module disp_track_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic [1:0]  inK = '0;
  logic [15:0] outData;
  logic [1:0]  outK;
  logic [1:0]  outDisp;
  logic        outRdEnd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit          refRd = 0;
  bit          pendIdle = 1;
  logic [15:0] pendData = '0;
  logic [1:0]  pendK = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_track u_disp_track (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inK(inK),
    .outData(outData), .outK(outK), .outDisp(outDisp), .outRdEnd(outRdEnd)
  );

  function automatic bit unbal6(input int x, input bit k);
    case (x)
      0, 1, 2, 4, 8, 15, 16, 23, 24, 27, 29, 30, 31: return 1;
      28: return k;
      default: return 0;
    endcase
  endfunction

  function automatic bit unbal4(input int y);
    return (y == 0) || (y == 4) || (y == 7);
  endfunction

  function automatic bit refFlip(input logic [7:0] b, input bit k);
    return unbal6(int'(b[4:0]), k) != unbal4(int'(b[7:5]));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compare the outputs for the pending word, then advance the model.
  task automatic compareStep();
    logic [15:0] eData;
    logic [1:0]  eK;
    bit f0, f1, s1, e;
    if (pendIdle) begin
      eData = {(refRd ? 8'hC5 : 8'h50), 8'hBC};
      eK = 2'b01;
      f0 = 1;
      f1 = (refRd ? 0 : 1);
    end else begin
      eData = pendData;
      eK = pendK;
      f0 = refFlip(pendData[7:0], pendK[0]);
      f1 = refFlip(pendData[15:8], pendK[1]);
    end
    s1 = refRd ^ f0;
    e = s1 ^ f1;
    if (pendIdle) begin
      chk("R7 idle comma/K", {outData[7:0], 6'd0, outK}, {8'hBC, 6'd0, 2'b01});
      chk("R8 idle variant", outData[15:8], eData[15:8]);
      chk("R9 idle end rd", outRdEnd, 0);
    end else begin
      chk("R2 data", outData, eData);
      chk("R2 K flags", outK, eK);
    end
    chk("R4 low start disp", outDisp[0], refRd);
    chk("R5 high start disp", outDisp[1], s1);
    chk("R6 end rd", outRdEnd, e);
    refRd = e;
  endtask

  task automatic sendWord(input bit v, input logic [15:0] d, input logic [1:0] k);
    @(negedge clk);
    compareStep();
    inValid = v;
    inData = d;
    inK = k;
    pendIdle = !v;
    pendData = d;
    pendK = k;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R0 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    repeat (3) @(negedge clk);
    // R1: reset state shows negative-disparity IDLE.
    chk("R1 reset data", outData, 16'h50BC);
    chk("R1 reset K", outK, 2'b01);
    chk("R1 reset rd", outDisp[0], 0);
    rstN = 1'b1;
    // Idle after negative rd.
    sendWord(0, 16'h0000, 2'b00);
    // R3: balanced D21.5 in both lanes, no flip.
    sendWord(1, 16'hB5B5, 2'b00);
    // R3: D0.0 unbalanced in both parts -> no flip.
    sendWord(1, 16'h0000, 2'b00);
    // R3: D3.0 flips low, D0.0 not -> rd goes positive.
    sendWord(1, 16'h0003, 2'b00);
    // R8: idle after positive rd selects D5.6.
    sendWord(0, 16'hFFFF, 2'b11);
    // R10: 0xBC with and without the control flag.
    sendWord(1, 16'hBCBC, 2'b01);
    sendWord(1, 16'hBCBC, 2'b00);
    sendWord(1, 16'hBCBC, 2'b11);
    sendWord(0, 16'h0000, 2'b00);
    sendWord(0, 16'h0000, 2'b00);
    // Back-to-back flipping words.
    sendWord(1, 16'h0303, 2'b00);
    sendWord(1, 16'h0300, 2'b00);
    sendWord(0, 16'h0000, 2'b00);
    // Random mix of data and IDLE.
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] d;
      logic [1:0] k;
      bit v;
      d = 16'($urandom(seed));
      seed = 0;
      k = 2'($urandom() % 8 == 0 ? $urandom() : 0);
      v = ($urandom() % 4) != 0;
      sendWord(v, d, k);
    end
    sendWord(0, 16'h0000, 2'b00);
    @(negedge clk);
    compareStep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule